// File: doc/BRIEF.md
# Output-Port Virtual Channel Credit Tracker

This block sits on one output port of a router. It keeps a credit count for each virtual channel (VC) in the input buffer of the next router. A send of a flit on a VC uses up one credit. A credit coming back from downstream restores one.

Every cycle the block offers a bypass VC, which critical flits can take without going through VC allocation. The bypass VC is the lowest-numbered VC that still has at least one credit. The block does not search for the fullest VC. Next to the bypass VC it drives an availability flag, which enables the crossbar bypass path. When no VC has credit, the flag drops and the bypass index keeps its last value.

The block also filters VC allocation requests. VC 0 is held back for latency-critical packets. A critical request may take any VC that has credit. A non-critical request may only take VCs 1 and up. A non-critical packet may still receive the VC that is currently offered as the bypass VC, because critical flits win any conflict further down the pipeline. A send on a VC with no credit is reported on an error output.

Top module: `vc_credit_tracker`

## Requirements
- R1: Reset state:
  - every VC holds VC_DEPTH credits (default 5 VCs of 5 flits each);
  - `free_mask` is all ones;
  - `vc_avail` is 1 and `byp_vc` is 0;
  - `send_err` is 0, and `elig_mask` is 0 while `req_vld` is 0.
- R2: A legal send on VC v (send_vld=1, send_vc=v) removes one credit at the next clock edge. Bit v of `free_mask` (bit v = VC v) falls in the cycle after the edge that took the last credit, and not before.
- R3: A credit return (`ret_vld` bit v = VC v) adds one credit to VC v. A legal send and a return on the same VC in the same cycle leave that VC's count unchanged.
- R4: While any VC has credit, `vc_avail` is 1 and `byp_vc` is the lowest index set in `free_mask`. The reserved VC 0 is included in this choice.
- R5: While no VC has credit, `vc_avail` is 0 and `byp_vc` keeps the value it had in the last cycle that had credit.
- R6: When `req_vld`=1 and `req_crit`=1, `elig_mask` equals `free_mask` in the same cycle. This includes VC 0.
- R7: When `req_vld`=1 and `req_crit`=0, `elig_mask` equals `free_mask` with bit 0 cleared. It may include the VC currently shown on `byp_vc`.
- R8: `send_err` is 1 in the same cycle as any send that targets a VC with zero credits or an index of NUM_VC or above. Such a send changes no credit count.
- R9: When `req_vld`=0, `elig_mask` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_vld | input | 1 | A flit is sent downstream this cycle |
| send_vc | input | VC_W (3) | VC index of the sent flit |
| ret_vld | input | NUM_VC (5) | Credit return, one bit per VC |
| req_vld | input | 1 | A VC allocation request is presented |
| req_crit | input | 1 | The request belongs to a latency-critical packet |
| byp_vc | output | VC_W (3) | VC offered to critical flits for bypass |
| vc_avail | output | 1 | At least one VC has credit; enables the bypass |
| free_mask | output | NUM_VC (5) | VCs holding at least one credit |
| elig_mask | output | NUM_VC (5) | VCs the current request may be granted |
| send_err | output | 1 | Send on an empty or out-of-range VC |

## Verification
Sends and returns are sampled at a clock edge, and they are seen in the counts one cycle later. So `free_mask`, `vc_avail` and `byp_vc` are checked after the following falling edge, once the input has been removed. `send_err` and `elig_mask` depend only on the present inputs and the present counts, so they are checked 1 ns after the inputs are driven, in the same cycle. The bench keeps its own credit count per VC and its own held bypass index, and it compares the outputs against these at those two sampling points.

// File: rtl/vct_pkg.sv
package vct_pkg;

  // Next credit count: a send on an empty VC is dropped, and the count
  // never exceeds the buffer depth.
  function automatic int credit_next(input int cur, input bit inc,
                                     input bit dec, input int depth);
    int n;
    n = cur;
    if (inc) n = n + 1;
    if (dec && cur > 0) n = n - 1;
    if (n > depth) n = depth;
    return n;
  endfunction

  // Lowest set bit index of a mask; returns -1 when the mask is empty.
  function automatic int lowest_set(input logic [31:0] mask, input int width);
    int idx;
    idx = -1;
    for (int i = width - 1; i >= 0; i--)
      if (mask[i]) idx = i;
    return idx;
  endfunction

endpackage

// File: rtl/vct_counter.sv
module vct_counter #(
  parameter int VC_DEPTH = 5,
  localparam int CNT_W = $clog2(VC_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             has_credit
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= CNT_W'(VC_DEPTH);
    else        cnt_q <= CNT_W'(vct_pkg::credit_next(int'(cnt_q), inc, dec, VC_DEPTH));
  end

  assign cnt        = cnt_q;
  assign has_credit = (cnt_q != '0);
endmodule

// File: rtl/vct_pick.sv
module vct_pick #(
  parameter int NUM_VC = 5,
  parameter int VC_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VC-1:0] free,
  output logic [VC_W-1:0]   byp_vc,
  output logic              avail
);
  logic [VC_W-1:0] held_q;
  int              first;

  always_comb begin
    first  = vct_pkg::lowest_set(32'(free), NUM_VC);
    avail  = (first >= 0);
    byp_vc = avail ? VC_W'(first) : held_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= byp_vc;
  end
endmodule

// File: rtl/vct_filter.sv
module vct_filter #(
  parameter int NUM_VC = 5
) (
  input  logic              req_vld,
  input  logic              req_crit,
  input  logic [NUM_VC-1:0] free,
  output logic [NUM_VC-1:0] elig
);
  localparam logic [NUM_VC-1:0] RSV_MASK = NUM_VC'(1);

  always_comb begin
    if (!req_vld)     elig = '0;
    else if (req_crit) elig = free;
    else              elig = free & ~RSV_MASK;
  end
endmodule

// File: rtl/vc_credit_tracker.sv
module vc_credit_tracker #(
  parameter int NUM_VC   = 5,
  parameter int VC_DEPTH = 5,
  localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int CNT_W = $clog2(VC_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send_vld,
  input  logic [VC_W-1:0]   send_vc,
  input  logic [NUM_VC-1:0] ret_vld,
  input  logic              req_vld,
  input  logic              req_crit,
  output logic [VC_W-1:0]   byp_vc,
  output logic              vc_avail,
  output logic [NUM_VC-1:0] free_mask,
  output logic [NUM_VC-1:0] elig_mask,
  output logic              send_err
);
  logic [NUM_VC-1:0]       send_hit;
  logic [NUM_VC*CNT_W-1:0] cnt_flat;
  logic                    idx_bad;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    assign send_hit[v] = send_vld && (int'(send_vc) == v);
    vct_counter #(.VC_DEPTH(VC_DEPTH)) cnt_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc        (ret_vld[v]),
      .dec        (send_hit[v]),
      .cnt        (cnt_flat[v*CNT_W +: CNT_W]),
      .has_credit (free_mask[v])
    );
  end

  assign idx_bad  = send_vld && (int'(send_vc) >= NUM_VC);
  assign send_err = idx_bad || (|(send_hit & ~free_mask));

  vct_pick #(.NUM_VC(NUM_VC), .VC_W(VC_W)) pick_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .free   (free_mask),
    .byp_vc (byp_vc),
    .avail  (vc_avail)
  );

  vct_filter #(.NUM_VC(NUM_VC)) filt_i (
    .req_vld  (req_vld),
    .req_crit (req_crit),
    .free     (free_mask),
    .elig     (elig_mask)
  );
endmodule

// File: rtl/vct_checker.sv
module vct_checker #(
  parameter int NUM_VC   = 5,
  parameter int VC_DEPTH = 5,
  parameter int VC_W     = 3,
  parameter int CNT_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              send_vld,
  input logic [VC_W-1:0]   send_vc,
  input logic [NUM_VC-1:0] ret_vld,
  input logic              req_vld,
  input logic              req_crit,
  input logic [VC_W-1:0]   byp_vc,
  input logic              vc_avail,
  input logic [NUM_VC-1:0] free_mask,
  input logic [NUM_VC-1:0] elig_mask,
  input logic              send_err,
  input logic [NUM_VC*CNT_W-1:0] cnt_flat
);
  function automatic logic [CNT_W-1:0] cnt_of(input logic [NUM_VC*CNT_W-1:0] f,
                                               input int i);
    return f[i*CNT_W +: CNT_W];
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      for (int v = 0; v < NUM_VC; v++)
        a_r1_no_overflow: assert (int'(cnt_of(cnt_flat, v)) <= VC_DEPTH);
    end
  end

  a_r2_send_takes_one: assert property (@(posedge clk) disable iff (!rst_n)
    (send_vld && !send_err && !ret_vld[send_vc]) |=>
      (cnt_of(cnt_flat, int'($past(send_vc))) ==
       CNT_W'(cnt_of($past(cnt_flat), int'($past(send_vc))) - 1'b1)));

  a_r4_pick_has_credit: assert property (@(posedge clk) disable iff (!rst_n)
    vc_avail |-> free_mask[byp_vc]);

  a_r4_pick_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    vc_avail |-> ((free_mask & ((NUM_VC'(1) << byp_vc) - NUM_VC'(1))) == '0));

  a_r5_hold_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !vc_avail |-> (byp_vc == $past(byp_vc)));

  a_r6_elig_has_credit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_crit) |-> ((elig_mask & ~free_mask) == '0));

  a_r7_noncrit_no_rsv: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_crit) |-> !elig_mask[0]);

  a_r8_err_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (send_err && int'(send_vc) < NUM_VC && !ret_vld[send_vc]) |=>
      (cnt_of(cnt_flat, int'($past(send_vc))) ==
       cnt_of($past(cnt_flat), int'($past(send_vc)))));

  a_r9_idle_no_elig: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |-> (elig_mask == '0));
endmodule

bind vc_credit_tracker vct_checker #(
  .NUM_VC(NUM_VC), .VC_DEPTH(VC_DEPTH), .VC_W(VC_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .send_vld(send_vld), .send_vc(send_vc),
  .ret_vld(ret_vld), .req_vld(req_vld), .req_crit(req_crit),
  .byp_vc(byp_vc), .vc_avail(vc_avail), .free_mask(free_mask),
  .elig_mask(elig_mask), .send_err(send_err), .cnt_flat(cnt_flat)
);

// File: tb/vc_credit_tracker_tb_top.sv
`timescale 1ns/1ps
module vc_credit_tracker_tb_top;
  localparam int NV  = 5;
  localparam int DEP = 5;
  localparam int VW  = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          send_vld;
  logic [VW-1:0] send_vc;
  logic [NV-1:0] ret_vld;
  logic          req_vld, req_crit;
  logic [VW-1:0] byp_vc;
  logic          vc_avail;
  logic [NV-1:0] free_mask, elig_mask;
  logic          send_err;

  int            model [NV];
  logic [VW-1:0] exp_byp;
  int            n_chk = 0;
  int            n_err = 0;

  always #2.5 clk = ~clk;

  vc_credit_tracker #(.NUM_VC(NV), .VC_DEPTH(DEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .send_vld(send_vld), .send_vc(send_vc),
    .ret_vld(ret_vld), .req_vld(req_vld), .req_crit(req_crit),
    .byp_vc(byp_vc), .vc_avail(vc_avail), .free_mask(free_mask),
    .elig_mask(elig_mask), .send_err(send_err)
  );

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [NV-1:0] exp_free();
    logic [NV-1:0] m;
    for (int v = 0; v < NV; v++) m[v] = (model[v] > 0);
    return m;
  endfunction

  // Compare registered outputs with the model; the model keeps the held index.
  task automatic check_state(input string rq);
    logic [NV-1:0] f;
    f = exp_free();
    if (f != '0) begin
      for (int v = NV - 1; v >= 0; v--) if (f[v]) exp_byp = VW'(v);
    end
    check(rq, "free_mask", 32'(free_mask), 32'(f));
    check(rq, "vc_avail", 32'(vc_avail), 32'(f != '0));
    check(rq, "byp_vc", 32'(byp_vc), 32'(exp_byp));
  endtask

  // One cycle of send/return; checks the error flag in the same cycle and
  // the counts after the edge.
  task automatic cycle(input string rq, input bit s, input int sv,
                       input logic [NV-1:0] rv);
    bit e;
    send_vld = s; send_vc = VW'(sv); ret_vld = rv;
    #1;
    e = s && (sv >= NV || model[sv] == 0);
    check(rq, "send_err", 32'(send_err), 32'(e));
    @(negedge clk);
    if (s && !e) model[sv]--;
    for (int v = 0; v < NV; v++) if (rv[v] && model[v] < DEP) model[v]++;
    send_vld = 1'b0; ret_vld = '0;
    #1;
    check_state(rq);
  endtask

  task automatic req_check(input string rq, input bit crit);
    logic [NV-1:0] f;
    f = exp_free();
    req_vld = 1'b1; req_crit = crit;
    #1;
    check(rq, crit ? "elig crit" : "elig noncrit", 32'(elig_mask),
          32'(crit ? f : (f & ~NV'(1))));
    req_vld = 1'b0;
    #1;
    check("R9", "elig idle", 32'(elig_mask), 32'h0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; send_vld = 0; send_vc = '0; ret_vld = '0;
    req_vld = 0; req_crit = 0;
    for (int v = 0; v < NV; v++) model[v] = DEP;
    exp_byp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check_state("R1");
    check("R1", "send_err", 32'(send_err), 32'h0);
    check("R1", "elig idle", 32'(elig_mask), 32'h0);
  endtask

  task automatic t_drain_rsv();
    for (int i = 0; i < DEP; i++) cycle("R2", 1, 0, '0);
    check("R4", "byp after VC0 drained", 32'(byp_vc), 32'd1);
  endtask

  task automatic t_double_assign();
    req_check("R7", 1'b0);
    check("R7", "bypass VC open to noncrit", 32'(exp_free()[byp_vc]), 32'd1);
    req_check("R6", 1'b1);
  endtask

  task automatic t_simultaneous();
    for (int i = 0; i < 3; i++) cycle("R3", 1, 1, NV'(2));
    for (int i = 0; i < DEP; i++) cycle("R3", 1, 1, '0);
    check("R3", "VC1 empties after depth sends", 32'(free_mask[1]), 32'd0);
  endtask

  task automatic t_return();
    cycle("R3", 0, 0, NV'(1));
    check("R4", "reserved VC picked again", 32'(byp_vc), 32'd0);
    req_check("R7", 1'b0);
    req_check("R6", 1'b1);
  endtask

  task automatic t_exhaust();
    cycle("R2", 1, 0, '0);
    for (int v = 2; v < NV; v++)
      for (int i = 0; i < DEP; i++) cycle("R4", 1, v, '0);
    check("R5", "vc_avail empty", 32'(vc_avail), 32'd0);
    check("R5", "byp held", 32'(byp_vc), 32'(NV - 1));
    repeat (2) @(negedge clk);
    #1 check("R5", "byp still held", 32'(byp_vc), 32'(NV - 1));
    req_check("R6", 1'b1);
  endtask

  task automatic t_errors();
    cycle("R8", 1, 2, '0);
    cycle("R8", 1, 7, '0);
    cycle("R8", 0, 0, NV'(4));
    check("R8", "VC2 back with one credit", 32'(byp_vc), 32'd2);
    cycle("R8", 1, 2, '0);
    cycle("R8", 1, 2, '0);
    check("R5", "byp held at 2", 32'(byp_vc), 32'd2);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_drain_rsv();
    t_double_assign();
    t_simultaneous();
    t_return();
    t_exhaust();
    t_errors();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule